// File: doc/BRIEF.md
# Valley Clock and Drive-Start Selector

This block sits between a zero-cross comparator and the gate-drive timing logic of a quasi-resonant converter. It turns the comparator flag into a valley clock. The comparator flag is high while the switch-node sense voltage is below the valley threshold. A valley clock pulse comes from one of two sources: a detected crossing into the below-threshold region, or a free-running timeout that stands in for valleys that are missing. The timeout supplies a clock at start-up and when the ringing is too damped to cross the threshold.

After each drive pulse, the selector waits for the end of the demagnetization window. It then counts valley clocks and issues a one-cycle drive-start pulse on the chosen valley. By default it picks the first valley at low line and the second at high line. A non-zero foldback request sets the valley number directly. A fault inhibit suppresses the pulse. Two states are used. HUNT counts valley clocks. WAIT holds off counting until the demagnetization end strobe arrives. The transition HUNT->WAIT fires on an issued drive-start pulse. The transition WAIT->HUNT fires on the demagnetization end strobe. Reset enters HUNT, so the first timeout clock can launch switching.

Top module: `valley_clk_sel`

## Requirements
- R1: During and right after reset, `vclk_o` and `drv_o` are 0, the selector is in HUNT with a zero count, and the timeout count is zero. The stored previous comparator level resets to 1, so a flag that is already high at release is not an edge.
- R2: A detected valley is a 0 in one clock sample of `zcd_below` followed by a 1 in the next. It makes `vclk_o` high for the one cycle after the clock edge that sampled the 1.
- R3: With no detected valley, `vclk_o` pulses once every `TMO_CYC` cycles. The first such pulse after reset follows the `TMO_CYC`-th clock edge.
- R4: Every valley clock, detected or generated, restarts the timeout. The next generated pulse therefore comes `TMO_CYC` cycles after the last clock of either kind.
- R5: A detected valley in the same cycle as a timeout expiry gives a single `vclk_o` pulse and advances the valley count by one.
- R6: With `fold_req` = 0 and `high_line` = 0, the drive-start pulse is issued on the first valley clock counted in HUNT.
- R7: With `fold_req` = 0 and `high_line` = 1, the drive-start pulse is issued on the second valley clock counted in HUNT.
- R8: With `fold_req` = N (1..7), the drive-start pulse is issued on the N-th counted valley clock, whatever the state of `high_line`. The target is sampled in the cycle of each valley clock.
- R9: While `fault_inh` is high at the valley clock that reaches the target, no drive-start pulse is issued. The count restarts from zero and the selector stays in HUNT.
- R10: After a drive-start, the selector is in WAIT, and valley clocks there are not counted. A `demag_end` strobe seen in WAIT starts a fresh count. A valley clock in that same cycle is not counted, and `demag_end` in HUNT has no effect.
- R11: `drv_o` is high for exactly one cycle, always together with a `vclk_o` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| zcd_below | input | 1 | Comparator flag, high while sense voltage is below the valley threshold |
| high_line | input | 1 | Line-range flag, 1 = high line |
| fold_req | input | FOLD_W | Foldback valley number, 0 = line-range default |
| fault_inh | input | 1 | Fault inhibit, blocks drive-start pulses |
| demag_end | input | 1 | Strobe marking the end of the demagnetization window |
| vclk_o | output | 1 | Valley clock pulse |
| drv_o | output | 1 | Drive-start pulse |

## Verification
Two clock sources can coincide in one cycle: a detected valley edge and a timeout expiry. The bench follows its own timeout count. It raises the comparator flag so that the sampled edge lands exactly on the expiry cycle. A correct result is one `vclk_o` pulse and a count advance of one, with the next timeout a full period later. The bench also puts a `demag_end` strobe in the same cycle as a detected edge in WAIT. There it expects that edge to go uncounted.

// File: rtl/vs_pkg.sv
package vs_pkg;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_WAIT = 1'b1
    } vs_state_e;

endpackage

// File: rtl/vs_clkgen.sv
// Valley clock source: comparator edge detection merged with a
// free-running timeout that restarts on every clock it emits.
module vs_clkgen #(
    parameter int TMO_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic zcd_below,
    output logic clk_evt,
    output logic vclk_o
);
    localparam int TW = $clog2(TMO_CYC + 1);
    localparam logic [TW-1:0] TMO_LAST = TW'(TMO_CYC - 1);

    logic          prev_q;
    logic [TW-1:0] tmo_q;
    logic          edge_hit;
    logic          tmo_hit;

    assign edge_hit = zcd_below & ~prev_q;
    assign tmo_hit  = (tmo_q == TMO_LAST);
    assign clk_evt  = edge_hit | tmo_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            tmo_q  <= '0;
            vclk_o <= 1'b0;
        end else begin
            prev_q <= zcd_below;
            tmo_q  <= clk_evt ? '0 : tmo_q + 1'b1;
            vclk_o <= clk_evt;
        end
    end
endmodule

// File: rtl/vs_target.sv
// Valley number selection: foldback request overrides the line default.
module vs_target #(
    parameter int FOLD_W = 3
) (
    input  logic              high_line,
    input  logic [FOLD_W-1:0] fold_req,
    output logic [FOLD_W-1:0] tgt
);
    localparam logic [FOLD_W-1:0] LOW_DEF  = FOLD_W'(1);
    localparam logic [FOLD_W-1:0] HIGH_DEF = FOLD_W'(2);

    always_comb begin
        if (fold_req != '0) begin
            tgt = fold_req;
        end else if (high_line) begin
            tgt = HIGH_DEF;
        end else begin
            tgt = LOW_DEF;
        end
    end
endmodule

// File: rtl/vs_fsm.sv
// HUNT/WAIT sequencer that counts valley clocks and issues drive-start.
module vs_fsm
    import vs_pkg::*;
#(
    parameter int FOLD_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_evt,
    input  logic [FOLD_W-1:0] tgt,
    input  logic              fault_inh,
    input  logic              demag_end,
    output logic              drv_o
);
    vs_state_e         st_q, st_d;
    logic [FOLD_W-1:0] cnt_q, cnt_d;
    logic [FOLD_W:0]   cnt_inc;
    logic              reach;
    logic              drv_d;

    assign cnt_inc = {1'b0, cnt_q} + 1'b1;
    assign reach   = (cnt_inc >= {1'b0, tgt});

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        drv_d = 1'b0;
        unique case (st_q)
            ST_HUNT: begin
                if (clk_evt) begin
                    if (reach) begin
                        cnt_d = '0;
                        if (!fault_inh) begin
                            drv_d = 1'b1;
                            st_d  = ST_WAIT;
                        end
                    end else begin
                        cnt_d = cnt_inc[FOLD_W-1:0];
                    end
                end
            end
            ST_WAIT: begin
                if (demag_end) begin
                    st_d  = ST_HUNT;
                    cnt_d = '0;
                end
            end
            default: begin
                st_d  = ST_HUNT;
                cnt_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_HUNT;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_o <= 1'b0;
        end else begin
            drv_o <= drv_d;
        end
    end
endmodule

// File: rtl/valley_clk_sel.sv
module valley_clk_sel #(
    parameter int TMO_CYC = 20,
    parameter int FOLD_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              zcd_below,
    input  logic              high_line,
    input  logic [FOLD_W-1:0] fold_req,
    input  logic              fault_inh,
    input  logic              demag_end,
    output logic              vclk_o,
    output logic              drv_o
);
    logic              clk_evt;
    logic [FOLD_W-1:0] tgt;

    vs_clkgen #(.TMO_CYC(TMO_CYC)) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .zcd_below (zcd_below),
        .clk_evt   (clk_evt),
        .vclk_o    (vclk_o)
    );

    vs_target #(.FOLD_W(FOLD_W)) u_target (
        .high_line (high_line),
        .fold_req  (fold_req),
        .tgt       (tgt)
    );

    vs_fsm #(.FOLD_W(FOLD_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_evt   (clk_evt),
        .tgt       (tgt),
        .fault_inh (fault_inh),
        .demag_end (demag_end),
        .drv_o     (drv_o)
    );
endmodule

// File: rtl/vs_chk.sv
module vs_chk #(
    parameter int TMO_CYC = 20
) (
    input logic clk,
    input logic rst_n,
    input logic vclk_o,
    input logic drv_o,
    input logic fault_inh,
    input logic demag_end
);
    logic [15:0] gap_q;
    logic        wait_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            wait_q <= 1'b0;
        end else begin
            gap_q  <= vclk_o ? 16'd0 : ((gap_q == 16'hFFFF) ? gap_q : gap_q + 16'd1);
            wait_q <= (drv_o | wait_q) & ~demag_end;
        end
    end

    // R11
    drv_with_vclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drv_o |-> vclk_o);

    // R9
    no_drive_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drv_o |-> !$past(fault_inh));

    // R10
    hold_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((drv_o | wait_q) & ~demag_end) |=> !drv_o);

    // R3
    tmo_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q <= 16'(TMO_CYC));
endmodule

bind valley_clk_sel vs_chk #(.TMO_CYC(TMO_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .vclk_o    (vclk_o),
    .drv_o     (drv_o),
    .fault_inh (fault_inh),
    .demag_end (demag_end)
);

// File: tb/sim_valley_clk_sel.sv
`timescale 1ns/1ps
module sim_valley_clk_sel;
    localparam int TMO = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       z = 1'b0;
    logic       hl = 1'b0;
    logic [2:0] fr = 3'd0;
    logic       fi = 1'b0;
    logic       de = 1'b0;
    logic       vclk_o, drv_o;

    int    checks = 0;
    int    fails  = 0;
    string cur    = "R1";

    // reference model state
    int m_prev = 1, m_tmo = 0, m_wait = 0, m_cnt = 0;
    int exp_vclk = 0, exp_drv = 0;

    always #5 clk = ~clk;

    valley_clk_sel #(.TMO_CYC(TMO), .FOLD_W(3)) u0 (
        .clk(clk), .rst_n(rst_n), .zcd_below(z), .high_line(hl),
        .fold_req(fr), .fault_inh(fi), .demag_end(de),
        .vclk_o(vclk_o), .drv_o(drv_o)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_prev = 1; m_tmo = 0; m_wait = 0; m_cnt = 0;
            exp_vclk = 0; exp_drv = 0;
        end else begin
            int ev;
            int tgt;
            ev = ((z && m_prev == 0) || m_tmo == TMO - 1) ? 1 : 0;
            exp_vclk = ev;
            exp_drv  = 0;
            tgt = (fr != 0) ? int'(fr) : (hl ? 2 : 1);
            if (m_wait == 1) begin
                if (de) begin m_wait = 0; m_cnt = 0; end
            end else if (ev == 1) begin
                if (m_cnt + 1 >= tgt) begin
                    m_cnt = 0;
                    if (!fi) begin exp_drv = 1; m_wait = 1; end
                end else begin
                    m_cnt = m_cnt + 1;
                end
            end
            m_tmo  = (ev == 1) ? 0 : m_tmo + 1;
            m_prev = z ? 1 : 0;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (int'(vclk_o) != exp_vclk || int'(drv_o) != exp_drv) begin
                fails++;
                $display("FAIL %s t=%0t vclk=%0d drv=%0d expected vclk=%0d drv=%0d",
                         cur, $time, vclk_o, drv_o, exp_vclk, exp_drv);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic valley();
        @(negedge clk) z = 1'b0;
        @(negedge clk) z = 1'b1;
    endtask

    task automatic run_valleys(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            idle(gap);
            valley();
        end
    endtask

    task automatic demag();
        @(negedge clk) de = 1'b1;
        @(negedge clk) de = 1'b0;
    endtask

    task automatic coincide();
        @(negedge clk) z = 1'b0;
        @(negedge clk);
        while (m_tmo != TMO - 1) @(negedge clk);
        z = 1'b1;
        idle(TMO + 2);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired in %s", cur);
        summary();
        $finish;
    end

    initial begin
        idle(3);
        // R1: outputs low in reset
        checks++;
        if (vclk_o !== 1'b0 || drv_o !== 1'b0) begin
            fails++;
            $display("FAIL R1 vclk=%0d drv=%0d expected 0 0", vclk_o, drv_o);
        end
        rst_n = 1'b1;
        // R3 / R6: timeout clocks start switching at low line
        cur = "R3 R6";
        idle(3 * TMO);
        // R2 / R6: detected valleys, first valley drives
        cur = "R2 R6";
        for (int k = 0; k < 3; k++) begin
            demag();
            run_valleys(1, 3);
        end
        // R7: high line, second valley
        cur = "R7";
        hl = 1'b1;
        demag(); run_valleys(2, 3);
        demag(); run_valleys(2, 4);
        // R8: foldback valley numbers override line range
        cur = "R8";
        fr = 3'd3; demag(); run_valleys(4, 2);
        fr = 3'd7; demag(); run_valleys(8, 2);
        hl = 1'b0; fr = 3'd5; demag(); idle(6 * TMO);
        // R4: a detected valley restarts the timeout
        cur = "R4";
        fr = 3'd0; hl = 1'b1; demag();
        idle(TMO / 2); valley(); idle(2 * TMO);
        // R5: detected edge on the timeout expiry cycle
        cur = "R5";
        fr = 3'd4; demag();
        coincide(); coincide();
        // R9: fault inhibit suppresses drive and restarts count
        cur = "R9";
        fr = 3'd0; hl = 1'b0; demag();
        fi = 1'b1;
        run_valleys(3, 2); idle(2 * TMO);
        fi = 1'b0;
        valley(); idle(4);
        // R10: no counting in WAIT, strobe coinciding with an edge
        cur = "R10";
        hl = 1'b1;
        run_valleys(3, 2);
        @(negedge clk) z = 1'b0;
        @(negedge clk) begin z = 1'b1; de = 1'b1; end
        @(negedge clk) de = 1'b0;
        run_valleys(2, 3);
        // R10: demag_end in HUNT has no effect
        demag();
        valley(); demag(); valley();
        // R11 is covered by every cycle's drive compare
        cur = "R11";
        idle(2 * TMO);
        summary();
        $finish;
    end
endmodule